// File: doc/BRIEF.md
# Dual DAC Register Interface

This block is the register front end of a two-channel 12-bit digital-to-analog converter, sitting on an 8-bit microcontroller special-function-register bus. Software writes a shared control byte and, for each channel, a low data byte and a high data byte. The block turns these into two 12-bit output codes plus per-channel range, clear and power controls that go straight to the analog side.

Each channel is double-buffered. Bus writes land in holding bytes. A separate latched code per channel feeds the output. Two update styles are supported. In the first, the sync bit of the control byte is held high, and each low-byte write commits that channel at once, so the high byte must be written first. In the second, the sync bit is held low while both channels' holding bytes are loaded, and then a single write that moves sync from 0 to 1 commits both channels on the same edge. In 8-bit mode only the low byte counts, and it fills the top eight bits of the code.

The bus is a single-cycle register port with no stall, so there is no back-pressure. Every write is taken on the clock edge where the strobe is high. Read data is combinational while the read strobe is high and zero otherwise.

Top module: `dacif_top`

## Requirements
- R1: After reset the control byte reads 04h, all four data bytes read 00h, both output codes are 000h, both power outputs are 0, both range outputs are 0 and both force-zero outputs are 1.
- R2: With the read strobe high, address FDh returns the control byte, F9h/FBh return the channel 0/1 low holding byte and FAh/FCh return the channel 0/1 high holding nibble with bits 7:4 reading 0. An unmapped address reads 00h, and read data is 00h whenever the read strobe is low.
- R3: While control bit 2 (sync) is 1 and bit 7 (mode) is 0, a write to a channel's low byte sets that channel's code to {high nibble, written byte} on the edge of the write. A high-byte write alone leaves the code unchanged.
- R4: While sync is 0, data-byte writes change only the holding bytes, and both latched codes stay unchanged.
- R5: A control write that changes sync from 0 to 1 loads both channels' codes from their holding bytes on the same edge. A control write that leaves sync at 1, or keeps it at 0, loads nothing.
- R6: With mode = 1 a channel's code is {low byte, 0000b}, and the high holding nibble has no effect.
- R7: Control bits 3 and 4 (clear, channel 0 and 1) at 0 force that channel's code to 000h and drive its force-zero output to 1. The holding and latched values are kept, and the old code returns when the bit goes back to 1.
- R8: Control bits 0 and 1 are the power enables of channels 0 and 1, and a 0 forces that channel's code to 000h. Bits 5 and 6 drive the range-select outputs of channels 0 and 1 (1 = supply range).
- R9: When one control write raises sync and also changes mode, the simultaneous update formats both codes with the newly written mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe |
| sfr_rdata | output | 8 | Read data |
| dac0_code | output | 12 | Channel 0 output code |
| dac1_code | output | 12 | Channel 1 output code |
| dac_rng_supply | output | 2 | Range select per channel, 1 = supply range |
| dac_pwr_on | output | 2 | Power enable per channel |
| dac_force_zero | output | 2 | Clear request per channel |

## Verification
The control write that raises sync is also the write that may change mode, so a simultaneous release and a format change can fall on the same edge. The bench loads both channels' holding bytes in 12-bit mode with sync low. It then writes one control byte that sets mode and sync together, and checks that both codes show the 8-bit format. It then drops sync and raises it again in 12-bit mode, and checks that both codes return to the right-justified format. The update of both channels on a single edge is judged by sampling both codes half a cycle after that one write.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int SFR_AW  = 8;
  localparam int SFR_DW  = 8;
  localparam int DAC_CW  = 12;
  localparam int DAC_NCH = 2;
  localparam logic [7:0] DATA_BASE  = 8'hF9;
  localparam logic [7:0] CTRL_ADDR  = 8'hFD;
  localparam logic [7:0] CTRL_RESET = 8'h04;
  // control bit positions (software-visible, hence fixed)
  localparam int B_MODE = 7;
  localparam int B_RNG0 = 5;
  localparam int B_CLR0 = 3;
  localparam int B_SYNC = 2;
  localparam int B_PD0  = 0;
endpackage

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int AW = SFR_AW,
  parameter int DW = SFR_DW,
  parameter logic [AW-1:0] ADDR = CTRL_ADDR,
  parameter logic [DW-1:0] RST_VAL = CTRL_RESET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  output logic [DW-1:0] ctrl_q,
  output logic          sync_rise,
  output logic          mode_next
);
  logic ctrl_wr;

  assign ctrl_wr = wr && (addr == ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= RST_VAL;
    else if (ctrl_wr) ctrl_q <= wdata;
  end

  // release both channels only on a 0 -> 1 edge of the sync bit
  assign sync_rise = ctrl_wr && !ctrl_q[B_SYNC] && wdata[B_SYNC];
  // the release formats with the mode being written in that same cycle
  assign mode_next = ctrl_wr ? wdata[B_MODE] : ctrl_q[B_MODE];
endmodule

// File: rtl/dacif_channel.sv
module dacif_channel #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 12,
  parameter logic [AW-1:0] LO_ADDR = 8'hF9,
  parameter logic [AW-1:0] HI_ADDR = 8'hFA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             wr,
  input  logic             mode8,
  input  logic             mode8_next,
  input  logic             sync_on,
  input  logic             sync_rise,
  input  logic             enable,
  output logic [DW-1:0]    lo_q,
  output logic [CW-DW-1:0] hi_q,
  output logic [CW-1:0]    lat_q,
  output logic [CW-1:0]    code
);
  localparam int HW = CW - DW;

  logic          lo_wr, hi_wr;
  logic [DW-1:0] lo_next;
  logic [HW-1:0] hi_next;
  logic [CW-1:0] lat_next;

  function automatic logic [CW-1:0] fmt(input logic m8,
                                        input logic [DW-1:0] lo,
                                        input logic [HW-1:0] hi);
    fmt = m8 ? {lo, {HW{1'b0}}} : {hi, lo};
  endfunction

  assign lo_wr   = wr && (addr == LO_ADDR);
  assign hi_wr   = wr && (addr == HI_ADDR);
  assign lo_next = lo_wr ? wdata : lo_q;
  assign hi_next = hi_wr ? wdata[HW-1:0] : hi_q;

  always_comb begin
    lat_next = lat_q;
    if (sync_rise)             lat_next = fmt(mode8_next, lo_next, hi_next);
    else if (sync_on && lo_wr) lat_next = fmt(mode8, lo_next, hi_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      lat_q <= '0;
    end else begin
      lo_q  <= lo_next;
      hi_q  <= hi_next;
      lat_q <= lat_next;
    end
  end

  assign code = enable ? lat_q : '0;
endmodule

// File: rtl/dacif_rdmux.sv
module dacif_rdmux #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 12,
  parameter int NCH = 2,
  parameter logic [AW-1:0] BASE = 8'hF9,
  parameter logic [AW-1:0] CADDR = 8'hFD
) (
  input  logic                          rd,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 ctrl_q,
  input  logic [NCH-1:0][DW-1:0]        lo_all,
  input  logic [NCH-1:0][CW-DW-1:0]     hi_all,
  output logic [DW-1:0]                 rdata
);
  localparam int HW = CW - DW;

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == CADDR) rdata = ctrl_q;
      for (int i = 0; i < NCH; i++) begin
        if (addr == AW'(int'(BASE) + 2 * i))     rdata = lo_all[i];
        if (addr == AW'(int'(BASE) + 2 * i + 1)) rdata = {{(DW - HW){1'b0}}, hi_all[i]};
      end
    end
  end
endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int AW = SFR_AW,
  parameter int DW = SFR_DW,
  parameter int CW = DAC_CW,
  parameter logic [AW-1:0] BASE  = DATA_BASE,
  parameter logic [AW-1:0] CADDR = CTRL_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sfr_addr,
  input  logic [DW-1:0] sfr_wdata,
  input  logic          sfr_wr,
  input  logic          sfr_rd,
  output logic [DW-1:0] sfr_rdata,
  output logic [CW-1:0] dac0_code,
  output logic [CW-1:0] dac1_code,
  output logic [1:0]    dac_rng_supply,
  output logic [1:0]    dac_pwr_on,
  output logic [1:0]    dac_force_zero
);
  localparam int NCH = DAC_NCH;
  localparam int HW  = CW - DW;

  logic [DW-1:0]          ctrl_q;
  logic                   sync_rise, mode_next;
  logic [NCH-1:0][DW-1:0] lo_all;
  logic [NCH-1:0][HW-1:0] hi_all;
  logic [NCH-1:0][CW-1:0] lat_all;
  logic [NCH-1:0][CW-1:0] code_all;

  dacif_ctrl #(.AW(AW), .DW(DW), .ADDR(CADDR), .RST_VAL(DW'(CTRL_RESET))) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wdata(sfr_wdata), .wr(sfr_wr),
    .ctrl_q(ctrl_q), .sync_rise(sync_rise), .mode_next(mode_next)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dacif_channel #(
      .AW(AW), .DW(DW), .CW(CW),
      .LO_ADDR(AW'(int'(BASE) + 2 * i)),
      .HI_ADDR(AW'(int'(BASE) + 2 * i + 1))
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wdata(sfr_wdata), .wr(sfr_wr),
      .mode8(ctrl_q[B_MODE]), .mode8_next(mode_next),
      .sync_on(ctrl_q[B_SYNC]), .sync_rise(sync_rise),
      .enable(ctrl_q[B_CLR0 + i] & ctrl_q[B_PD0 + i]),
      .lo_q(lo_all[i]), .hi_q(hi_all[i]), .lat_q(lat_all[i]), .code(code_all[i])
    );
    assign dac_rng_supply[i] = ctrl_q[B_RNG0 + i];
    assign dac_pwr_on[i]     = ctrl_q[B_PD0 + i];
    assign dac_force_zero[i] = ~ctrl_q[B_CLR0 + i];
  end

  assign dac0_code = code_all[0];
  assign dac1_code = code_all[1];

  dacif_rdmux #(.AW(AW), .DW(DW), .CW(CW), .NCH(NCH), .BASE(BASE), .CADDR(CADDR)) u_rd (
    .rd(sfr_rd), .addr(sfr_addr), .ctrl_q(ctrl_q),
    .lo_all(lo_all), .hi_all(hi_all), .rdata(sfr_rdata)
  );
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sfr_addr,
  input logic [7:0]  sfr_wdata,
  input logic        sfr_wr,
  input logic        sfr_rd,
  input logic [7:0]  sfr_rdata,
  input logic [7:0]  ctrl_q,
  input logic [11:0] lat0,
  input logic [11:0] lat1,
  input logic [11:0] dac0_code,
  input logic [11:0] dac1_code
);
  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_rd |-> sfr_rdata == 8'h00);

  assert_commit12_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2] && !ctrl_q[7] && sfr_wr && sfr_addr == 8'hF9) |=> lat0[7:0] == $past(sfr_wdata));

  assert_hold_nosync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !(sfr_wr && sfr_addr == 8'hFD)) |=> ($stable(lat0) && $stable(lat1)));

  assert_commit8_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2] && ctrl_q[7] && sfr_wr && sfr_addr == 8'hFB) |=> lat1 == {$past(sfr_wdata), 4'h0});

  assert_clear0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[3] |-> dac0_code == 12'h000);

  assert_clear1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4] |-> dac1_code == 12'h000);

  assert_pwr0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> dac0_code == 12'h000);

  assert_pwr1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[1] |-> dac1_code == 12'h000);
endmodule

bind dacif_top dacif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
  .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata), .ctrl_q(ctrl_q),
  .lat0(lat_all[0]), .lat1(lat_all[1]), .dac0_code(dac0_code), .dac1_code(dac1_code)
);

// File: tb/tb_dacif_top.sv
`timescale 1ns/1ps
module tb_dacif_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic        sfr_wr = 1'b0;
  logic        sfr_rd = 1'b0;
  logic [7:0]  sfr_rdata;
  logic [11:0] dac0_code, dac1_code;
  logic [1:0]  dac_rng_supply, dac_pwr_on, dac_force_zero;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dacif_top dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
    .dac0_code(dac0_code), .dac1_code(dac1_code),
    .dac_rng_supply(dac_rng_supply), .dac_pwr_on(dac_pwr_on), .dac_force_zero(dac_force_zero)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // write takes effect at the next rising edge; returns at the following falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    sfr_addr = a; sfr_rd = 1'b1;
    #1 check(req, sfr_rdata, exp);
    sfr_rd = 1'b0;
  endtask

  task automatic codes(input string req, input logic [11:0] e0, input logic [11:0] e1);
    check(req, dac0_code, e0);
    check(req, dac1_code, e1);
  endtask

  task automatic t_reset;
    codes("R1 codes", 12'h000, 12'h000);
    check("R1 pwr", dac_pwr_on, 2'b00);
    check("R1 rng", dac_rng_supply, 2'b00);
    check("R1 fz", dac_force_zero, 2'b11);
    rd_chk("R1 ctrl", 8'hFD, 8'h04);
    rd_chk("R1 lo0", 8'hF9, 8'h00);
    rd_chk("R1 hi1", 8'hFC, 8'h00);
  endtask

  task automatic t_sync_commit;
    wr(8'hFD, 8'h1F);
    wr(8'hFA, 8'hA5);
    rd_chk("R2 hi nibble", 8'hFA, 8'h05);
    check("R3 hi alone", dac0_code, 12'h000);
    wr(8'hF9, 8'h3C);
    check("R3 ch0", dac0_code, 12'h53C);
    wr(8'hFC, 8'h07);
    wr(8'hFB, 8'hFF);
    codes("R3 ch1", 12'h53C, 12'h7FF);
    wr(8'hFA, 8'h02);
    check("R3 hi no effect", dac0_code, 12'h53C);
  endtask

  task automatic t_nosync_hold;
    wr(8'hFD, 8'h1B);
    wr(8'hF9, 8'h11); wr(8'hFA, 8'h01);
    wr(8'hFB, 8'h22); wr(8'hFC, 8'h03);
    codes("R4 hold", 12'h53C, 12'h7FF);
    rd_chk("R4 lo1 holding", 8'hFB, 8'h22);
  endtask

  task automatic t_sync_rise;
    wr(8'hFD, 8'h1F);
    codes("R5 both", 12'h111, 12'h322);
    wr(8'hFD, 8'h1B);
    wr(8'hFA, 8'h09);
    wr(8'hFD, 8'h1B);
    check("R5 no rise", dac0_code, 12'h111);
    wr(8'hFD, 8'h1F);
    check("R5 rise again", dac0_code, 12'h911);
    wr(8'hFD, 8'h1F);
    check("R5 sync held", dac0_code, 12'h911);
  endtask

  task automatic t_mode8;
    wr(8'hFD, 8'h9F);
    wr(8'hF9, 8'hAB);
    check("R6 ch0", dac0_code, 12'hAB0);
    wr(8'hFB, 8'hCD);
    check("R6 ch1", dac1_code, 12'hCD0);
  endtask

  task automatic t_same_edge;
    wr(8'hFD, 8'h1B);
    wr(8'hF9, 8'h44); wr(8'hFA, 8'h06);
    wr(8'hFD, 8'h9F);
    codes("R9 mode8 rise", 12'h440, 12'hCD0);
    wr(8'hFD, 8'h9B);
    wr(8'hFD, 8'h1F);
    codes("R9 mode12 rise", 12'h644, 12'h3CD);
  endtask

  task automatic t_clear_pwr;
    wr(8'hFD, 8'h17);
    codes("R7 clear0", 12'h000, 12'h3CD);
    check("R7 fz", dac_force_zero, 2'b01);
    rd_chk("R7 kept", 8'hF9, 8'h44);
    wr(8'hFD, 8'h1F);
    check("R7 restore", dac0_code, 12'h644);
    wr(8'hFD, 8'h1D);
    codes("R8 pwr1 off", 12'h644, 12'h000);
    check("R8 pwr", dac_pwr_on, 2'b01);
    wr(8'hFD, 8'h7F);
    check("R8 rng", dac_rng_supply, 2'b11);
    codes("R8 back on", 12'h644, 12'h3CD);
  endtask

  task automatic t_read_map;
    rd_chk("R2 ctrl", 8'hFD, 8'h7F);
    rd_chk("R2 hi1", 8'hFC, 8'h03);
    rd_chk("R2 unmapped", 8'hF8, 8'h00);
    @(negedge clk);
    sfr_addr = 8'hFD;
    #1 check("R2 rd low", sfr_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync_commit();
    t_nosync_hold();
    t_sync_rise();
    t_mode8();
    t_same_edge();
    t_clear_pwr();
    t_read_map();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule